// File: doc/BRIEF.md
# Fractional Overhead Insertion Multiplexer

This block sits in a serial transmit payload path and merges a stream of fractional overhead bits into a payload stream that arrives one bit per clock enable from an upstream cell or packet processor. Each valid bit period is classified as payload, line overhead/stuff, or fractional overhead. Payload and line-overhead periods pass the payload bit through. Overhead periods replace it with a bit taken from the selected overhead source.

The overhead window comes from one of two places, chosen by a configuration bit. In external mode a window input from outside the device marks the overhead periods, and the window output is held low. In internal mode a window generated by a separate controller marks the periods, the external window input is ignored, and that window is driven out on the window output. A 2-bit source field picks the inserted data: constant zero, constant one, an alternating pattern, or an external overhead data input. All inputs are sampled on one clock, and both outputs are registered.

The alternating pattern comes from a two-state machine. It is reset to state PH_HIGH, which emits 1. It takes transition STEP_DOWN (PH_HIGH to PH_LOW) or STEP_UP (PH_LOW to PH_HIGH) on every inserted overhead bit, and holds its state otherwise. Each valid period is classified into one of the slot kinds SLOT_PAY, SLOT_LINE or SLOT_OVH. A cycle without clock enable is SLOT_IDLE.

Top module: `fohm_insert_mux`

## Requirements
- R1: While rst_n is low, ser_out and win_out are 0 and the alternating state is PH_HIGH, so the first alternating overhead bit after reset is 1.
- R2: A cycle with bit_en=1 updates ser_out and win_out at the next rising clock edge (one-clock latency). A cycle with bit_en=0 leaves both outputs unchanged.
- R3: With cfg_int_mode=1 the overhead window is int_win and ext_win has no effect. With cfg_int_mode=0 the window is ext_win and int_win has no effect.
- R4: In internal mode, win_out takes int_win AND NOT line_ohd from each valid bit. In external mode, win_out is 0.
- R5: On an overhead bit, cfg_src selects the inserted value: 2'b00 gives 0, 2'b01 gives 1, 2'b10 gives the alternating pattern, and 2'b11 gives ovh_data.
- R6: The alternating state toggles once on every inserted overhead bit, whatever the source. It does not toggle on payload bits, on line-overhead bits, or on cycles with bit_en=0.
- R7: A valid bit with line_ohd=1 outputs pay_bit even when the selected window is high, and inserts nothing.
- R8: A valid bit whose selected window is low outputs pay_bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all inputs and outputs |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Clock enable: marks a valid bit period |
| pay_bit | input | 1 | Payload bit from the upstream processor |
| ovh_data | input | 1 | External overhead data bit |
| ext_win | input | 1 | External overhead window |
| int_win | input | 1 | Internally generated overhead window |
| line_ohd | input | 1 | Line overhead/stuff period qualifier |
| cfg_int_mode | input | 1 | 1 = internal window, 0 = external window |
| cfg_src | input | 2 | Overhead source select |
| ser_out | output | 1 | Merged serial output, registered |
| win_out | output | 1 | Overhead window output, registered |

## Verification
The assertions check several rules on every cycle: outputs hold when bit_en is low, win_out stays low in external mode, payload passes through during line overhead, constant-one insertion, and that the alternating state toggles exactly on inserted bits. Some behaviour only the bench scenarios can show. These are that the first alternating bit after reset is 1, that the unselected window input is ignored, that the external data is routed correctly, and that the whole output sequence matches across mixed mode and source changes, checked against a scoreboard model.

// File: rtl/fohm_pkg.sv
package fohm_pkg;
    localparam int SRC_W = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_ZERO = 2'b00,
        SRC_ONE  = 2'b01,
        SRC_ALT  = 2'b10,
        SRC_EXT  = 2'b11
    } ovh_src_e;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_PAY  = 2'd1,
        SLOT_LINE = 2'd2,
        SLOT_OVH  = 2'd3
    } slot_e;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } alt_ph_e;
endpackage

// File: rtl/fohm_slot_classify.sv
module fohm_slot_classify
    import fohm_pkg::*;
(
    input  logic  bit_en,
    input  logic  ext_win,
    input  logic  int_win,
    input  logic  line_ohd,
    input  logic  int_mode,
    output slot_e slot
);
    logic sel_win;

    always_comb begin
        sel_win = int_mode ? int_win : ext_win;
        if (!bit_en)
            slot = SLOT_IDLE;
        else if (line_ohd)
            slot = SLOT_LINE;
        else if (sel_win)
            slot = SLOT_OVH;
        else
            slot = SLOT_PAY;
    end
endmodule

// File: rtl/fohm_alt_fsm.sv
module fohm_alt_fsm
    import fohm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic alt_bit
);
    alt_ph_e state_q, state_d;
    logic    past_ok;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_HIGH;
            past_ok <= 1'b0;
        end else begin
            state_q <= state_d;
            past_ok <= 1'b1;
        end
    end

    // next state and output
    always_comb begin
        state_d = state_q;
        alt_bit = 1'b1;
        unique case (state_q)
            PH_HIGH: begin
                alt_bit = 1'b1;
                if (step) state_d = PH_LOW;   // STEP_DOWN
            end
            PH_LOW: begin
                alt_bit = 1'b0;
                if (step) state_d = PH_HIGH;  // STEP_UP
            end
        endcase
    end

    // R6: state changes exactly on inserted bits
    a_r6_toggle_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(step)) |-> (state_q != $past(state_q)));
    a_r6_hold_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(step)) |-> $stable(state_q));
endmodule

// File: rtl/fohm_src_mux.sv
module fohm_src_mux
    import fohm_pkg::*;
(
    input  logic [SRC_W-1:0] src,
    input  logic             alt_bit,
    input  logic             ovh_data,
    output logic             ovh_bit
);
    ovh_src_e src_e;

    always_comb begin
        src_e = ovh_src_e'(src);
        unique case (src_e)
            SRC_ZERO: ovh_bit = 1'b0;
            SRC_ONE:  ovh_bit = 1'b1;
            SRC_ALT:  ovh_bit = alt_bit;
            SRC_EXT:  ovh_bit = ovh_data;
        endcase
    end
endmodule

// File: rtl/fohm_insert_mux.sv
module fohm_insert_mux
    import fohm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             pay_bit,
    input  logic             ovh_data,
    input  logic             ext_win,
    input  logic             int_win,
    input  logic             line_ohd,
    input  logic             cfg_int_mode,
    input  logic [SRC_W-1:0] cfg_src,
    output logic             ser_out,
    output logic             win_out
);
    slot_e slot;
    logic  alt_bit, ovh_bit, step;
    logic  ser_d, win_d;
    logic  past_ok;

    fohm_slot_classify u_class (
        .bit_en   (bit_en),
        .ext_win  (ext_win),
        .int_win  (int_win),
        .line_ohd (line_ohd),
        .int_mode (cfg_int_mode),
        .slot     (slot)
    );

    assign step = (slot == SLOT_OVH);

    fohm_alt_fsm u_alt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .alt_bit (alt_bit)
    );

    fohm_src_mux u_mux (
        .src      (cfg_src),
        .alt_bit  (alt_bit),
        .ovh_data (ovh_data),
        .ovh_bit  (ovh_bit)
    );

    // output next values, per slot kind
    always_comb begin
        ser_d = ser_out;
        win_d = win_out;
        unique case (slot)
            SLOT_IDLE: begin
                ser_d = ser_out;
                win_d = win_out;
            end
            SLOT_PAY: begin
                ser_d = pay_bit;
                win_d = 1'b0;
            end
            SLOT_LINE: begin
                ser_d = pay_bit;
                win_d = 1'b0;
            end
            SLOT_OVH: begin
                ser_d = ovh_bit;
                win_d = cfg_int_mode;
            end
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out <= 1'b0;
            win_out <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            ser_out <= ser_d;
            win_out <= win_d;
            past_ok <= 1'b1;
        end
    end

    // R2: no clock enable, outputs hold
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(bit_en)) |-> ($stable(ser_out) && $stable(win_out)));
    // R4: external mode never raises the window output
    a_r4_ext_win_low: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bit_en) && !$past(cfg_int_mode)) |-> !win_out);
    // R7: line overhead passes payload
    a_r7_line_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bit_en) && $past(line_ohd)) |-> (ser_out == $past(pay_bit)));
    // R5: constant-one source
    a_r5_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(step) && ($past(cfg_src) == 2'b01)) |-> ser_out);
endmodule

// File: tb/fohm_insert_mux_tb_top.sv
module fohm_insert_mux_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0, pay_bit = 1'b0, ovh_data = 1'b0;
    logic       ext_win = 1'b0, int_win = 1'b0, line_ohd = 1'b0, cfg_int_mode = 1'b0;
    logic [1:0] cfg_src = 2'b00;
    logic       ser_out, win_out;

    int vectors = 0;
    int errs = 0;
    bit done = 1'b0;

    typedef struct {
        logic  s;
        logic  w;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    // model state
    logic m_ser = 1'b0, m_win = 1'b0, m_ph = 1'b1;

    always #5 clk = ~clk;

    fohm_insert_mux dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pay_bit(pay_bit),
        .ovh_data(ovh_data), .ext_win(ext_win), .int_win(int_win),
        .line_ohd(line_ohd), .cfg_int_mode(cfg_int_mode), .cfg_src(cfg_src),
        .ser_out(ser_out), .win_out(win_out)
    );

    task automatic drive(input logic en, input logic p, input logic od,
                         input logic ew, input logic iw, input logic ln,
                         input logic md, input logic [1:0] sr, input string tag);
        exp_t e;
        logic ins;
        @(negedge clk);
        bit_en = en; pay_bit = p; ovh_data = od; ext_win = ew;
        int_win = iw; line_ohd = ln; cfg_int_mode = md; cfg_src = sr;
        if (en) begin
            ins = (md ? iw : ew) & ~ln;
            if (ins) begin
                case (sr)
                    2'b00: m_ser = 1'b0;
                    2'b01: m_ser = 1'b1;
                    2'b10: m_ser = m_ph;
                    default: m_ser = od;
                endcase
                m_ph = ~m_ph;
            end else begin
                m_ser = p;
            end
            m_win = md & iw & ~ln;
        end
        e.s = m_ser; e.w = m_win; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            vectors++;
            if (ser_out !== e.s || win_out !== e.w) begin
                errs++;
                $display("FAIL %s: ser_out=%b win_out=%b expected ser_out=%b win_out=%b",
                         e.tag, ser_out, win_out, e.s, e.w);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        vectors++;
        if (ser_out !== 1'b0 || win_out !== 1'b0) begin
            errs++;
            $display("FAIL R1: reset ser_out=%b win_out=%b expected 0 0", ser_out, win_out);
        end
        rst_n = 1'b1;

        // R1/R6: alternating pattern starts at 1, external mode
        for (int i = 0; i < 6; i++) drive(1, 0, 0, 1, 0, 0, 0, 2'b10, "R1_R6_alt");
        // R6: no toggle on payload, line, idle
        drive(1, 1, 0, 0, 0, 0, 0, 2'b10, "R8_pay");
        drive(1, 0, 0, 1, 0, 1, 0, 2'b10, "R7_line");
        drive(0, 1, 1, 1, 1, 0, 0, 2'b10, "R2_idle");
        drive(0, 0, 1, 1, 1, 0, 1, 2'b01, "R2_idle");
        drive(1, 0, 0, 1, 0, 0, 0, 2'b10, "R6_alt_resume");
        drive(1, 0, 0, 1, 0, 0, 0, 2'b10, "R6_alt_resume");
        // R5: zeros, ones, external
        drive(1, 1, 1, 1, 0, 0, 0, 2'b00, "R5_zero");
        drive(1, 0, 0, 1, 0, 0, 0, 2'b01, "R5_one");
        drive(1, 0, 1, 1, 0, 0, 0, 2'b11, "R5_ext");
        drive(1, 1, 0, 1, 0, 0, 0, 2'b11, "R5_ext");
        // R6: toggle during non-alt insertion, then alt
        drive(1, 0, 0, 1, 0, 0, 0, 2'b10, "R6_alt_after_const");
        // R3: external mode ignores int_win
        drive(1, 1, 0, 0, 1, 0, 0, 2'b00, "R3_ext_ignores_int");
        // R7: line overhead with window
        drive(1, 1, 0, 1, 1, 1, 1, 2'b00, "R7_line_int");
        drive(1, 0, 1, 1, 0, 1, 0, 2'b11, "R7_line_ext");
        // R3/R4: internal mode
        drive(1, 1, 0, 1, 0, 0, 1, 2'b00, "R3_int_ignores_ext");
        drive(1, 1, 0, 0, 1, 0, 1, 2'b00, "R4_int_win");
        drive(1, 0, 0, 0, 1, 0, 1, 2'b01, "R4_int_win");
        drive(0, 1, 1, 0, 0, 0, 1, 2'b00, "R2_hold_win");
        drive(1, 1, 0, 0, 0, 0, 1, 2'b00, "R8_int_pay");
        // mixed random traffic
        for (int i = 0; i < 400; i++)
            drive(1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom_range(0, 4) == 0), 1'($urandom),
                  2'($urandom), "R2_R3_R5_R6_mixed");
        @(negedge clk);
        bit_en = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule